// File: doc/BRIEF.md
# Four-Phase Interpolating Time Digitizer

The block measures how long an asynchronous time pulse stays high, in units of one fast reference clock period. A four-stage Johnson ring runs on the reference clock and produces four phase outputs. Each ring state differs from the one before it in a single bit, so the phases form a Gray-coded sequence that repeats every eight reference cycles. A coarse counter advances once per ring revolution. When the pulse ends, the ring state is sampled and decoded to a three-bit fine count. The result is the coarse count with the fine count appended as its low bits.

The pulse is first brought into the clock domain through a two-stage synchroniser. After every result the ring is held stopped and cleared for a fixed recovery interval, so that the next measurement starts from a known phase. A two-bit selector picks one of four full-scale windows. A pulse that outlasts the chosen window ends the measurement with an overflow code. A pulse that is still high when recovery ends must first go low before the block arms again.

Top module: `tdc_interp`

## Requirements
- R1: While reset is held, phase_o is 0000, and busy_o, osc_stop_o, res_valid_o, ovf_o and res_o are all 0.
- R2: While idle, the ring stays at 0000. During a measurement it steps once per clock through 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 and repeats, changing exactly one bit per step. The first step is 0001, seen three clock edges after the pulse rises.
- R3: A pulse that is high for N clock periods (1 <= N <= window) yields res_o = N with ovf_o = 0. In res_o, bits [2:0] hold the decoded ring state and bits [10:3] hold the count of full ring revolutions. res_valid_o is a one-cycle pulse that follows the third clock edge after the pulse falls.
- R4: res_sel_i selects the window in clock periods: 0 gives 200, 1 gives 325, 2 gives 581 and 3 gives 1044. The selector is sampled when a measurement starts. A pulse exactly as long as the window is measured normally.
- R5: A pulse longer than the window ends the measurement at the window limit. It gives res_valid_o with ovf_o = 1 and res_o = 2047, three clock periods plus the window length after the pulse rose.
- R6: From the cycle res_valid_o is high, osc_stop_o stays high for exactly 50 cycles. During that time phase_o is 0000.
- R7: A pulse that rises and falls while osc_stop_o is high produces no result, and the block returns to idle.
- R8: A pulse still high when recovery ends keeps busy_o high with no new result until the pulse falls. The next pulse is then measured normally.
- R9: res_o and ovf_o keep their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pulse_i | input | 1 | Asynchronous time pulse to be measured |
| res_sel_i | input | 2 | Full-scale window select |
| phase_o | output | 4 | Ring phase outputs |
| busy_o | output | 1 | High from measurement start until the block is re-armed |
| osc_stop_o | output | 1 | High while the ring is held stopped after a result |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| ovf_o | output | 1 | The last result overflowed the window |
| res_o | output | 11 | Last result: coarse count then fine bits |

## Verification
On every cycle the assertions check several properties of the ring and the result strobe. While a measurement runs, the ring changes one bit per step. The ring sits at zero whenever the block is idle or stopped. The result strobe lasts one cycle and always opens the stop interval. Overflow results carry the saturated code, and the result holds still between strobes. Only the bench scenarios can show the rest. These are the measured values against pulse length, the latency of the strobe, the boundary at each window length, and the exact 50-cycle stop. They also cover pulses that are ignored during recovery and the re-arm after a pulse that stays high.

// File: rtl/tdc_interp_pkg.sv
package tdc_interp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } tdc_state_e;
endpackage

// File: rtl/tdc_pulse_sync.sv
module tdc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~last_q;
  assign fall_o  = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tdc_phase_ring.sv
module tdc_phase_ring #(
  parameter int PHASES = 4,
  localparam int FINE_W = $clog2(2 * PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              clr_i,
  output logic [PHASES-1:0] phase_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              wrap_o
);
  localparam logic [FINE_W:0]   TWO_P    = (FINE_W + 1)'(2 * PHASES);
  localparam logic [PHASES-1:0] LAST_ST  = {1'b1, {(PHASES - 1){1'b0}}};

  logic [PHASES-1:0] ring_q, ring_d;
  logic [FINE_W:0]   ones;
  logic [FINE_W:0]   fine_full;

  always_comb begin
    ring_d = ring_q;
    if (clr_i)      ring_d = '0;
    else if (adv_i) ring_d = {ring_q[PHASES-2:0], ~ring_q[PHASES-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < PHASES; i++) begin
      ones = ones + {{FINE_W{1'b0}}, ring_q[i]};
    end
    fine_full = ring_q[PHASES-1] ? (TWO_P - ones) : ones;
  end

  assign fine_o  = fine_full[FINE_W-1:0];
  assign wrap_o  = (ring_q == LAST_ST);
  assign phase_o = ring_q;
endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_interp_pkg::*;
#(
  parameter int RES_W    = 11,
  parameter int HOLD_CYC = 50,
  parameter int FS_0     = 200,
  parameter int FS_1     = 325,
  parameter int FS_2     = 581,
  parameter int FS_3     = 1044
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [1:0]       res_sel_i,
  input  logic [RES_W-1:0] count_i,
  output logic             ring_adv_o,
  output logic             ring_clr_o,
  output logic             coarse_clr_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             osc_stop_o,
  output logic             res_valid_o,
  output logic             ovf_o,
  output logic [RES_W-1:0] res_o
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CYC - 1);

  tdc_state_e       state_q, state_d;
  logic [HC_W-1:0]  hold_q, hold_d;
  logic [RES_W-1:0] lim_q, lim_d, sel_lim;
  logic [RES_W-1:0] res_q, res_d;
  logic             ovf_q, ovf_d;
  logic             vld_q, vld_d;

  always_comb begin
    case (res_sel_i)
      2'd0:    sel_lim = RES_W'(FS_0);
      2'd1:    sel_lim = RES_W'(FS_1);
      2'd2:    sel_lim = RES_W'(FS_2);
      default: sel_lim = RES_W'(FS_3);
    endcase
  end

  always_comb begin
    state_d      = state_q;
    hold_d       = hold_q;
    lim_d        = lim_q;
    res_d        = res_q;
    ovf_d        = ovf_q;
    vld_d        = 1'b0;
    ring_adv_o   = 1'b0;
    ring_clr_o   = 1'b0;
    coarse_clr_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rise_i) begin
          coarse_clr_o = 1'b1;
          ring_adv_o   = 1'b1;
          lim_d        = sel_lim;
          state_d      = ST_RUN;
        end else begin
          ring_clr_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (fall_i) begin
          res_d      = count_i;
          ovf_d      = 1'b0;
          vld_d      = 1'b1;
          ring_clr_o = 1'b1;
          hold_d     = '0;
          state_d    = ST_HOLD;
        end else if (count_i == lim_q) begin
          res_d      = '1;
          ovf_d      = 1'b1;
          vld_d      = 1'b1;
          ring_clr_o = 1'b1;
          hold_d     = '0;
          state_d    = ST_HOLD;
        end else begin
          ring_adv_o = 1'b1;
        end
      end
      ST_HOLD: begin
        ring_clr_o = 1'b1;
        if (hold_q == HOLD_LAST) begin
          state_d = level_i ? ST_DRAIN : ST_IDLE;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: begin
        ring_clr_o = 1'b1;
        if (!level_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      lim_q   <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      lim_q   <= lim_d;
      res_q   <= res_d;
      ovf_q   <= ovf_d;
      vld_q   <= vld_d;
    end
  end

  assign run_o       = (state_q == ST_RUN);
  assign busy_o      = (state_q != ST_IDLE);
  assign osc_stop_o  = (state_q == ST_HOLD);
  assign res_valid_o = vld_q;
  assign ovf_o       = ovf_q;
  assign res_o       = res_q;
endmodule

// File: rtl/tdc_interp.sv
module tdc_interp #(
  parameter int PHASES      = 4,
  parameter int COARSE_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 50,
  parameter int FS_0        = 200,
  parameter int FS_1        = 325,
  parameter int FS_2        = 581,
  parameter int FS_3        = 1044,
  localparam int FINE_W     = $clog2(2 * PHASES),
  localparam int RES_W      = COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_i,
  input  logic [1:0]        res_sel_i,
  output logic [PHASES-1:0] phase_o,
  output logic              busy_o,
  output logic              osc_stop_o,
  output logic              res_valid_o,
  output logic              ovf_o,
  output logic [RES_W-1:0]  res_o
);
  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic                level_w, rise_w, fall_w;
  logic                ring_adv_w, ring_clr_w, coarse_clr_w, wrap_w, run_w;
  logic [FINE_W-1:0]   fine_w;
  logic [COARSE_W-1:0] coarse_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tdc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pulse_i),
    .level_o (level_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  tdc_phase_ring #(.PHASES(PHASES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv_i   (ring_adv_w),
    .clr_i   (ring_clr_w),
    .phase_o (phase_o),
    .fine_o  (fine_w),
    .wrap_o  (wrap_w)
  );

  tdc_coarse_ctr #(.WIDTH(COARSE_W)) u_coarse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (coarse_clr_w),
    .inc_i   (ring_adv_w & wrap_w),
    .count_o (coarse_w)
  );

  tdc_ctrl #(
    .RES_W    (RES_W),
    .HOLD_CYC (HOLD_CYC),
    .FS_0     (FS_0),
    .FS_1     (FS_1),
    .FS_2     (FS_2),
    .FS_3     (FS_3)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .level_i      (level_w),
    .rise_i       (rise_w),
    .fall_i       (fall_w),
    .res_sel_i    (res_sel_i),
    .count_i      ({coarse_w, fine_w}),
    .ring_adv_o   (ring_adv_w),
    .ring_clr_o   (ring_clr_w),
    .coarse_clr_o (coarse_clr_w),
    .run_o        (run_w),
    .busy_o       (busy_o),
    .osc_stop_o   (osc_stop_o),
    .res_valid_o  (res_valid_o),
    .ovf_o        (ovf_o),
    .res_o        (res_o)
  );
endmodule

// File: rtl/tdc_interp_chk.sv
module tdc_interp_chk #(
  parameter int PHASES = 4,
  parameter int RES_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [PHASES-1:0] phase_o,
  input logic              busy_o,
  input logic              osc_stop_o,
  input logic              res_valid_o,
  input logic              ovf_o,
  input logic [RES_W-1:0]  res_o
);
  AST_RING_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (osc_stop_o || $countones(phase_o ^ $past(phase_o)) == 1)); // R2

  AST_IDLE_RING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (phase_o == '0)); // R2

  AST_STOP_RING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop_o |-> (phase_o == '0)); // R6

  AST_VALID_STARTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> osc_stop_o); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o); // R3

  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && ovf_o) |-> (&res_o)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> ($stable(res_o) && $stable(ovf_o))); // R9
endmodule

bind tdc_interp tdc_interp_chk #(.PHASES(PHASES), .RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .run         (run_w),
  .phase_o     (phase_o),
  .busy_o      (busy_o),
  .osc_stop_o  (osc_stop_o),
  .res_valid_o (res_valid_o),
  .ovf_o       (ovf_o),
  .res_o       (res_o)
);

// File: tb/test_tdc_interp.sv
`timescale 1ns/1ps
module test_tdc_interp;
  localparam int HOLD = 50;

  logic        clk;
  logic        rst_n;
  logic        pulse_i;
  logic [1:0]  res_sel_i;
  logic [3:0]  phase_o;
  logic        busy_o, osc_stop_o, res_valid_o, ovf_o;
  logic [10:0] res_o;

  int errors = 0;
  int checks = 0;

  tdc_interp i_tdc_interp (
    .clk (clk), .rst_n (rst_n), .pulse_i (pulse_i), .res_sel_i (res_sel_i),
    .phase_o (phase_o), .busy_o (busy_o), .osc_stop_o (osc_stop_o),
    .res_valid_o (res_valid_o), .ovf_o (ovf_o), .res_o (res_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int win(input int sel);
    case (sel)
      0: return 200;
      1: return 325;
      2: return 581;
      default: return 1044;
    endcase
  endfunction

  function automatic logic [3:0] jstate(input int k);
    logic [3:0] s = 4'b0000;
    for (int i = 0; i < k; i++) s = {s[2:0], ~s[3]};
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: pulse of n cycles -> result n after three edges
  task automatic measure(input int sel, input int n);
    res_sel_i = 2'(sel);
    pulse_i = 1'b1;
    repeat (n) @(negedge clk);
    pulse_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(res_valid_o == 1'b0, "R3 latency", int'(res_valid_o), 0);
    @(negedge clk);
    chk(res_valid_o == 1'b1, "R3 valid", int'(res_valid_o), 1);
    chk(int'(res_o) == n && ovf_o == 1'b0, "R3 value", int'(res_o), n);
    chk(int'(res_o[2:0]) == n % 8, "R3 fine bits", int'(res_o[2:0]), n % 8);
    repeat (HOLD + 5) @(negedge clk);
  endtask

  // R5: pulse of m > window cycles -> overflow at window limit
  task automatic overflow(input int sel, input int m);
    int lim = win(sel);
    res_sel_i = 2'(sel);
    pulse_i = 1'b1;
    for (int c = 1; c <= lim + 3; c++) begin
      @(negedge clk);
      if (c == m) pulse_i = 1'b0;
    end
    chk(res_valid_o == 1'b1 && ovf_o == 1'b1, "R5 overflow flag", int'(ovf_o), 1);
    chk(int'(res_o) == 2047, "R5 saturated", int'(res_o), 2047);
    if (m > lim + 3) repeat (m - lim - 3) @(negedge clk);
    pulse_i = 1'b0;
    repeat (HOLD + 5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cnt;
    int nv;
    bit ph_ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    pulse_i = 1'b0;
    res_sel_i = 2'd0;
    repeat (4) @(negedge clk);
    chk(phase_o == 4'b0000 && busy_o == 1'b0 && osc_stop_o == 1'b0,
        "R1 reset state", int'(phase_o), 0);
    chk(res_valid_o == 1'b0 && ovf_o == 1'b0 && res_o == '0,
        "R1 reset result", int'(res_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: ring sequence during a 20-cycle pulse
    res_sel_i = 2'd0;
    pulse_i = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 1; k <= 10; k++) begin
      chk(phase_o == jstate(k), "R2 ring sequence", int'(phase_o), int'(jstate(k)));
      @(negedge clk);
    end
    repeat (7) @(negedge clk);
    pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid_o == 1'b1 && int'(res_o) == 20, "R3 20-cycle pulse", int'(res_o), 20);

    // R6: stop interval length and ring clear
    cnt = 0;
    ph_ok = 1'b1;
    while (osc_stop_o && cnt < 200) begin
      cnt++;
      if (phase_o != 4'b0000) ph_ok = 1'b0;
      @(negedge clk);
    end
    chk(cnt == HOLD, "R6 stop length", cnt, HOLD);
    chk(ph_ok, "R6 ring clear while stopped", int'(ph_ok), 1);
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b0 && phase_o == 4'b0000, "R2 idle ring zero", int'(phase_o), 0);

    // directed small and boundary values
    measure(0, 1);
    measure(1, 7);
    measure(2, 8);
    measure(3, 9);
    for (int s = 0; s < 4; s++) measure(s, win(s)); // R4 exact window

    // R9: result held between results
    repeat (30) @(negedge clk);
    chk(int'(res_o) == win(3) && ovf_o == 1'b0, "R9 result held", int'(res_o), win(3));

    // R5: one cycle beyond window, and a long pulse
    overflow(3, win(3) + 1);
    overflow(1, win(1) + 2);

    // R7: pulse during stop interval is ignored
    pulse_i = 1'b1;
    repeat (30) @(negedge clk);
    pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_i = 1'b1;
    repeat (10) @(negedge clk);
    pulse_i = 1'b0;
    nv = 0;
    repeat (80) begin
      @(negedge clk);
      if (res_valid_o) nv++;
    end
    chk(nv == 0, "R7 pulse in stop ignored", nv, 0);
    chk(busy_o == 1'b0, "R7 back to idle", int'(busy_o), 0);
    chk(int'(res_o) == 30, "R7 result unchanged", int'(res_o), 30);

    // R8: pulse held past recovery must fall before re-arm
    res_sel_i = 2'd0;
    pulse_i = 1'b1;
    repeat (win(0) + 3) @(negedge clk);
    chk(ovf_o == 1'b1, "R8 overflow before drain", int'(ovf_o), 1);
    nv = 0;
    repeat (100) begin
      @(negedge clk);
      if (res_valid_o) nv++;
    end
    chk(nv == 0 && busy_o == 1'b1, "R8 held while pulse high", int'(busy_o), 1);
    pulse_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0, "R8 re-armed", int'(busy_o), 0);
    measure(0, 37);

    // random lengths within window
    for (int i = 0; i < 16; i++) begin
      int sel = int'($urandom % 4);
      int n = 1 + int'($urandom % win(sel));
      measure(sel, n);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule